// File: doc/BRIEF.md
# Burst DMA Transfer Sequencer

This block drives one DMA channel that copies a run of data units from a source address range to a destination address range. Software loads a unit count and the two start addresses, then pulses the enable input. After a fixed start latency the sequencer becomes a bus master. For each unit it issues a read cycle at the source address, keeps the returned data in a holding register, and then issues a write cycle at the destination address. Units follow each other with no idle cycle between them until the count is used up. The enable flag then clears by itself.

A mode input sets how the sequencer shares the bus. With the mode at 0 it keeps the bus from the first read to the last write and ignores requests from other masters. With the mode at 1 it checks the other masters' request line at each unit boundary. If the line is high it releases the bus, waits until the request drops, and then continues with the read of the next unit.

Requests from other DMA channels are collected while a burst runs. They are granted one at a time, lowest index first, once the burst is over.

Top module: `burst_dma_seq`

## Requirements
- R1: After reset, `busy`, `bus_cyc`, `bus_yield`, `end_strobe` and `chan_grant` are all 0.
- R2: When `en_set` is sampled high while idle, `busy` rises at that edge. The first `bus_cyc` rises exactly START_LAT (default 3) clock edges later.
- R3: Each unit is a read (`bus_we`=0) at the source address followed by a write (`bus_we`=1) at the destination address. The write data equals `bus_rdata` as sampled at the read's `bus_ack`. A bus cycle holds its address and direction until `bus_ack`.
- R4: The source address advances by UNIT_BYTES (default 2) after each completed read. The destination address advances by UNIT_BYTES after each completed write. The count decrements after each completed write.
- R5: Between the first read and the final write, `bus_cyc` never drops unless the bus is released under R8. `busy` is 0 in the cycle after the final write's `bus_ack`.
- R6: `end_strobe` is high during the final write cycle of a burst and at no other time.
- R7: With `yield_mode`=0, `ext_breq` has no effect: `bus_yield` stays 0 and the burst timing is unchanged.
- R8: With `yield_mode`=1 and `ext_breq` high at a unit boundary, `bus_yield` is 1 and `bus_cyc` is 0 from the next cycle for as long as `ext_breq` stays high. The read of the next unit starts in the cycle after `ext_breq` drops. A unit is never split or repeated.
- R9: `chan_req` bits are held as pending. `chan_grant` is one-hot or zero and is never high while `busy`. In the cycle after the final write's `bus_ack`, the lowest pending index is granted, and the next pending index is granted one cycle later.
- R10: While `busy`, `en_set`, `cnt_load`, `src_load` and `dst_load` have no effect on the running burst.
- R11: A count of zero at enable clears `busy` START_LAT edges after enable, with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | 1 | Pulse that sets the enable flag |
| yield_mode | input | 1 | 1: release the bus to other masters at unit boundaries |
| cnt_load | input | 1 | Load the unit count (idle only) |
| cnt_value | input | CW | Unit count to load |
| src_load | input | 1 | Load the source address (idle only) |
| src_value | input | AW | Source start address |
| dst_load | input | 1 | Load the destination address (idle only) |
| dst_value | input | AW | Destination start address |
| bus_cyc | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | Completes the current bus cycle at the clock edge |
| ext_breq | input | 1 | Another master requests the bus |
| bus_yield | output | 1 | Bus released to another master |
| end_strobe | output | 1 | Final write cycle of the burst |
| busy | output | 1 | Enable flag |
| chan_req | input | NCH | Transfer requests from other channels |
| chan_grant | output | NCH | One-cycle grant to a pending channel |

## Verification
The bench drives inputs on the falling edge and reads outputs on the next falling edge. A result therefore shows up one falling edge for each register it passes through. `busy` is seen at the first falling edge after enable. The first read shows after START_LAT further edges. With an acknowledge delay of w, each unit takes 2(w+1) cycles, so a burst of N units keeps `busy` high for exactly START_LAT+2N(w+1) falling edges. The first grant appears at the falling edge where `busy` first reads 0. Release and resume are checked edge by edge against the falling edge on which the bench changes `ext_breq`.

// File: rtl/dma_seq_pkg.sv
// Shared types for the burst DMA sequencer.
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAT,
        ST_READ,
        ST_WRITE,
        ST_YIELD
    } seq_state_e;
endpackage

// File: rtl/dma_seq_fsm.sv
// Control sequencer: owns the enable flag, the start-latency count and the
// read/write/yield state. Assumes bus_ack is only meaningful during a bus cycle
// and that START_LAT is at least 1.
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int START_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_set,
    input  logic       yield_mode,
    input  logic       ext_breq,
    input  logic       bus_ack,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output seq_state_e state_q,
    output logic       en_q,
    output logic       en_nxt,
    output logic       rd_done,
    output logic       wr_done
);
    localparam int LW = $clog2(START_LAT + 1);

    seq_state_e     state_d;
    seq_state_e     unit_next;
    logic           en_d;
    logic [LW-1:0]  lat_q, lat_d;

    // State at a unit boundary: release the bus or start the next read.
    always_comb unit_next = (yield_mode && ext_breq) ? ST_YIELD : ST_READ;

    // Next-state, enable and latency logic.
    always_comb begin
        state_d = state_q;
        en_d    = en_q;
        lat_d   = lat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_set) begin
                    en_d    = 1'b1;
                    lat_d   = LW'(1);
                    state_d = ST_LAT;
                end
            end
            ST_LAT: begin
                if (lat_q == LW'(START_LAT)) begin
                    if (cnt_zero) begin
                        en_d    = 1'b0;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = unit_next;
                    end
                end else begin
                    lat_d = lat_q + LW'(1);
                end
            end
            ST_READ: begin
                if (bus_ack) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (bus_ack) begin
                    if (cnt_last) begin
                        en_d    = 1'b0;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = unit_next;
                    end
                end
            end
            ST_YIELD: begin
                if (!ext_breq) state_d = ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, enable and latency registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
            lat_q   <= lat_d;
        end
    end

    // Completion strobes and look-ahead enable for the datapath and the grant logic.
    always_comb begin
        en_nxt  = en_d;
        rd_done = (state_q == ST_READ)  && bus_ack;
        wr_done = (state_q == ST_WRITE) && bus_ack;
    end
endmodule

// File: rtl/dma_addr_reg.sv
// Loadable address register that steps by a fixed unit size.
// Assumes load and advance never occur together; load wins if they do.
module dma_addr_reg #(
    parameter int AW   = 16,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_value,
    input  logic          advance,
    output logic [AW-1:0] addr_q
);
    // Address update: load from software or step after a completed access.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (load)    addr_q <= load_value;
        else if (advance) addr_q <= addr_q + AW'(STEP);
    end
endmodule

// File: rtl/dma_seq_path.sv
// Datapath: unit count, source and destination address registers and the
// read-data holding register. Loads are accepted only while load_ok is high.
module dma_seq_path #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CW         = 8,
    parameter int UNIT_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_ok,
    input  logic          cnt_load,
    input  logic [CW-1:0] cnt_value,
    input  logic          src_load,
    input  logic [AW-1:0] src_value,
    input  logic          dst_load,
    input  logic [AW-1:0] dst_value,
    input  logic          rd_done,
    input  logic          wr_done,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [DW-1:0] buf_q,
    output logic          cnt_zero,
    output logic          cnt_last
);
    localparam int NPTR = 2;

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] ptr_value [NPTR];
    logic [AW-1:0] ptr_q     [NPTR];
    logic          ptr_load  [NPTR];
    logic          ptr_step  [NPTR];

    // Map source (0) and destination (1) onto the shared pointer slots.
    always_comb begin
        ptr_value[0] = src_value;
        ptr_load[0]  = src_load && load_ok;
        ptr_step[0]  = rd_done;
        ptr_value[1] = dst_value;
        ptr_load[1]  = dst_load && load_ok;
        ptr_step[1]  = wr_done;
        src_q        = ptr_q[0];
        dst_q        = ptr_q[1];
    end

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        dma_addr_reg #(.AW(AW), .STEP(UNIT_BYTES)) i_ptr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (ptr_load[gi]),
            .load_value (ptr_value[gi]),
            .advance    (ptr_step[gi]),
            .addr_q     (ptr_q[gi])
        );
    end

    // Unit counter: load while idle, count down per completed write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (cnt_load && load_ok) cnt_q <= cnt_value;
        else if (wr_done)            cnt_q <= cnt_q - CW'(1);
    end

    // Holding register for the data returned by the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_q <= '0;
        else if (rd_done) buf_q <= bus_rdata;
    end

    // Terminal-count decodes for the sequencer.
    always_comb begin
        cnt_zero = (cnt_q == '0);
        cnt_last = (cnt_q == CW'(1));
    end
endmodule

// File: rtl/dma_chan_hold.sv
// Holds transfer requests from other channels and issues one-cycle one-hot
// grants, lowest index first, only while grant_ok is high.
module dma_chan_hold #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_req,
    input  logic           grant_ok,
    output logic [NCH-1:0] chan_grant
);
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] all_req;
    logic [NCH-1:0] pick;
    logic [NCH-1:0] grant_d;

    // Lowest set bit of the pending and incoming requests.
    always_comb begin
        all_req = pend_q | chan_req;
        pick    = all_req & (~all_req + NCH'(1));
        grant_d = grant_ok ? pick : '0;
    end

    // Pending set and grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            chan_grant <= '0;
        end else begin
            pend_q     <= all_req & ~grant_d;
            chan_grant <= grant_d;
        end
    end
endmodule

// File: rtl/burst_dma_seq.sv
// Single-channel burst DMA sequencer with dual-address read/write units,
// an optional bus-release mode and holding of other channels' requests.
// Assumes the bus slave holds bus_ack for exactly one cycle per access.
module burst_dma_seq
    import dma_seq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CW         = 8,
    parameter int NCH        = 4,
    parameter int START_LAT  = 3,
    parameter int UNIT_BYTES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_set,
    input  logic           yield_mode,
    input  logic           cnt_load,
    input  logic [CW-1:0]  cnt_value,
    input  logic           src_load,
    input  logic [AW-1:0]  src_value,
    input  logic           dst_load,
    input  logic [AW-1:0]  dst_value,
    output logic           bus_cyc,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ack,
    input  logic           ext_breq,
    output logic           bus_yield,
    output logic           end_strobe,
    output logic           busy,
    input  logic [NCH-1:0] chan_req,
    output logic [NCH-1:0] chan_grant
);
    seq_state_e    state_q;
    logic          en_q, en_nxt, rd_done, wr_done;
    logic          cnt_zero, cnt_last;
    logic [AW-1:0] src_q, dst_q;
    logic [DW-1:0] buf_q;

    dma_seq_fsm #(.START_LAT(START_LAT)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .yield_mode (yield_mode),
        .ext_breq   (ext_breq),
        .bus_ack    (bus_ack),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .state_q    (state_q),
        .en_q       (en_q),
        .en_nxt     (en_nxt),
        .rd_done    (rd_done),
        .wr_done    (wr_done)
    );

    dma_seq_path #(.AW(AW), .DW(DW), .CW(CW), .UNIT_BYTES(UNIT_BYTES)) i_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_ok   (!en_q),
        .cnt_load  (cnt_load),
        .cnt_value (cnt_value),
        .src_load  (src_load),
        .src_value (src_value),
        .dst_load  (dst_load),
        .dst_value (dst_value),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .bus_rdata (bus_rdata),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .buf_q     (buf_q),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last)
    );

    dma_chan_hold #(.NCH(NCH)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_req   (chan_req),
        .grant_ok   (!en_nxt),
        .chan_grant (chan_grant)
    );

    // Bus-side decodes of the sequencer state.
    always_comb begin
        bus_cyc    = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_we     = (state_q == ST_WRITE);
        bus_addr   = bus_we ? dst_q : src_q;
        bus_wdata  = buf_q;
        bus_yield  = (state_q == ST_YIELD);
        end_strobe = (state_q == ST_WRITE) && cnt_last;
        busy       = en_q;
    end
endmodule

// File: rtl/dma_seq_chk.sv
// Protocol checker for burst_dma_seq, attached by bind. Observes ports only.
module dma_seq_chk #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int NCH       = 4,
    parameter int START_LAT = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           yield_mode,
    input logic           ext_breq,
    input logic           bus_cyc,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic           bus_ack,
    input logic           bus_yield,
    input logic           end_strobe,
    input logic           busy,
    input logic [NCH-1:0] chan_req,
    input logic [NCH-1:0] chan_grant
);
    localparam int AGW = $clog2(START_LAT + 1);

    logic [AGW-1:0] age_q;
    logic           unused_req;

    always_comb unused_req = ^chan_req;

    // Saturating count of cycles since the enable flag rose.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)              age_q <= '0;
        else if (age_q != AGW'(START_LAT)) age_q <= age_q + AGW'(1);
    end

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (age_q == AGW'(START_LAT))); // R2
    AST_CYCLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_we))); // R3
    AST_WRITE_CARRIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_we && bus_ack) |=> (bus_cyc && bus_we && bus_wdata == $past(bus_rdata))); // R3
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && bus_ack && !end_strobe && !yield_mode) |=> (bus_cyc && !bus_we)); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && bus_ack && end_strobe) |=> !busy); // R5
    AST_END_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        end_strobe |-> (bus_cyc && bus_we)); // R6
    AST_YIELD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_yield) |-> ($past(yield_mode) && $past(ext_breq))); // R7
    AST_YIELD_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_yield |-> !bus_cyc); // R8
    AST_RESUME_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_yield && !ext_breq) |=> (bus_cyc && !bus_we)); // R8
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_grant)); // R9
    AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_grant) |-> !busy); // R9
endmodule

bind burst_dma_seq dma_seq_chk #(
    .AW(AW), .DW(DW), .NCH(NCH), .START_LAT(START_LAT)
) i_chk (.*);

// File: tb/test_burst_dma_seq.sv
`timescale 1ns/1ps
module test_burst_dma_seq;
    localparam int AW = 16, DW = 16, CW = 8, NCH = 4, LAT = 3, UB = 2;

    logic           clk = 1'b0, rst_n = 1'b0;
    logic           en_set = 0, yield_mode = 0, cnt_load = 0, src_load = 0, dst_load = 0;
    logic [CW-1:0]  cnt_value = '0;
    logic [AW-1:0]  src_value = '0, dst_value = '0;
    logic           bus_cyc, bus_we, bus_yield, end_strobe, busy;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata;
    logic [DW-1:0]  bus_rdata = '0;
    logic           bus_ack = 0, ext_breq = 0;
    logic [NCH-1:0] chan_req = '0, chan_grant;

    int total = 0, bad = 0;
    int slave_wait = 0, wcnt = 0;
    int nlog = 0, end_hits = 0, grant_busy = 0;
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    logic          log_we   [64];
    logic          log_end  [64];
    int lat_n, gap_n, yld_n, busy_n;

    burst_dma_seq i_burst_dma_seq (.*);

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // Bus slave model and monitor: acknowledges after slave_wait extra cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            wcnt = 0;
        end else if (bus_cyc) begin
            if (wcnt >= slave_wait) begin
                bus_ack   <= 1'b1;
                bus_rdata <= pat(bus_addr);
                if (nlog < 64) begin
                    log_addr[nlog] = bus_addr;
                    log_data[nlog] = bus_wdata;
                    log_we[nlog]   = bus_we;
                    log_end[nlog]  = end_strobe;
                end
                nlog++;
                wcnt = 0;
            end else begin
                bus_ack <= 1'b0;
                wcnt++;
            end
        end else begin
            bus_ack <= 1'b0;
            wcnt = 0;
        end
        if (rst_n && end_strobe) end_hits++;
        if (rst_n && busy && (|chan_grant)) grant_busy++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load registers and pulse enable; returns at the first falling edge after enable.
    task automatic start_burst(input logic [AW-1:0] s, input logic [AW-1:0] d,
                               input int n, input logic mode);
        @(negedge clk);
        src_load = 1; src_value = s; dst_load = 1; dst_value = d;
        cnt_load = 1; cnt_value = CW'(n); yield_mode = mode;
        @(negedge clk);
        src_load = 0; dst_load = 0; cnt_load = 0; en_set = 1;
        nlog = 0;
        @(negedge clk);
        en_set = 0;
    endtask

    // Follow the burst until busy drops, collecting latency, gap and yield counts.
    task automatic run_to_done();
        bit started = 0;
        lat_n = 0; gap_n = 0; yld_n = 0; busy_n = 0;
        for (int i = 0; i < 5000; i++) begin
            if (!busy) break;
            busy_n++;
            if (bus_yield) yld_n++;
            if (bus_cyc) started = 1;
            else if (!started) lat_n++;
            else if (!bus_yield) gap_n++;
            @(negedge clk);
        end
    endtask

    task automatic check_log(input string req, input logic [AW-1:0] s,
                             input logic [AW-1:0] d, input int n);
        chk({req, " op count"}, nlog, 2 * n);
        for (int i = 0; i < n && 2 * i + 1 < 64; i++) begin
            chk({req, " read dir"}, int'(log_we[2*i]), 0);
            chk({req, " read addr"}, int'(log_addr[2*i]), int'(AW'(s + AW'(UB * i))));
            chk({req, " write dir"}, int'(log_we[2*i+1]), 1);
            chk({req, " write addr"}, int'(log_addr[2*i+1]), int'(AW'(d + AW'(UB * i))));
            chk({req, " write data"}, int'(log_data[2*i+1]), int'(pat(AW'(s + AW'(UB * i)))));
            chk({req, " R6 end flag"}, int'(log_end[2*i+1]), (i == n - 1) ? 1 : 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 bus_cyc", int'(bus_cyc), 0);
        chk("R1 bus_yield", int'(bus_yield), 0);
        chk("R1 end_strobe", int'(end_strobe), 0);
        chk("R1 chan_grant", int'(chan_grant), 0);
    endtask

    task automatic t_basic(input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input int n, input int w);
        int e0;
        slave_wait = w;
        e0 = end_hits;
        start_burst(s, d, n, 1'b0);
        run_to_done();
        chk("R2 start latency", lat_n, LAT);
        chk("R5 no gaps", gap_n, 0);
        chk("R5 busy length", busy_n, LAT + 2 * n * (w + 1));
        check_log("R3 R4", s, d, n);
        chk("R6 end strobe cycles", end_hits - e0, w + 1);
    endtask

    task automatic t_hold();
        slave_wait = 1;
        ext_breq = 1;
        start_burst(16'h0010, 16'h0A00, 3, 1'b0);
        run_to_done();
        chk("R7 no yield", yld_n, 0);
        chk("R7 no gaps", gap_n, 0);
        chk("R7 busy length", busy_n, LAT + 2 * 3 * 2);
        check_log("R7", 16'h0010, 16'h0A00, 3);
        ext_breq = 0;
    endtask

    task automatic t_yield();
        slave_wait = 0;
        start_burst(16'h0300, 16'h0500, 3, 1'b1);
        for (int i = 0; i < 50; i++) begin
            if (bus_cyc && bus_we) break;
            @(negedge clk);
        end
        ext_breq = 1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R8 released", int'(bus_yield && !bus_cyc), 1);
        end
        ext_breq = 0;
        @(negedge clk);
        chk("R8 resume read", int'(bus_cyc && !bus_we), 1);
        chk("R8 resume addr", int'(bus_addr), 16'h0302);
        run_to_done();
        check_log("R8", 16'h0300, 16'h0500, 3);
        yield_mode = 0;
    endtask

    task automatic t_grant();
        slave_wait = 0;
        grant_busy = 0;
        start_burst(16'h0100, 16'h0200, 4, 1'b0);
        chan_req = 4'b0100;
        @(negedge clk);
        chan_req = 4'b0010;
        @(negedge clk);
        chan_req = 4'b0000;
        run_to_done();
        chk("R9 no grant while busy", grant_busy, 0);
        chk("R9 first grant", int'(chan_grant), 4'b0010);
        @(negedge clk);
        chk("R9 second grant", int'(chan_grant), 4'b0100);
        @(negedge clk);
        chk("R9 grants drained", int'(chan_grant), 0);
        chan_req = 4'b1000;
        @(negedge clk);
        chan_req = 4'b0000;
        chk("R9 idle grant", int'(chan_grant), 4'b1000);
        @(negedge clk);
        chk("R9 idle grant pulse", int'(chan_grant), 0);
    endtask

    task automatic t_ignore();
        int e0;
        slave_wait = 1;
        e0 = end_hits;
        start_burst(16'h0040, 16'h0080, 3, 1'b0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        cnt_load = 1; cnt_value = 8'd9; src_load = 1; src_value = 16'h7000;
        dst_load = 1; dst_value = 16'h7800; en_set = 1;
        @(negedge clk);
        cnt_load = 0; src_load = 0; dst_load = 0; en_set = 0;
        run_to_done();
        check_log("R10", 16'h0040, 16'h0080, 3);
        chk("R10 single end", end_hits - e0, 2);
        repeat (6) @(negedge clk);
        chk("R10 no restart", int'(busy), 0);
    endtask

    task automatic t_zero();
        start_burst(16'h0000, 16'h0000, 0, 1'b0);
        run_to_done();
        chk("R11 busy length", busy_n, LAT);
        chk("R11 no bus cycle", nlog, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic(16'h1000, 16'h2000, 4, 0);
        t_basic(16'hFFFC, 16'h0420, 2, 2);
        t_hold();
        t_yield();
        t_grant();
        t_ignore();
        t_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule